// File: doc/BRIEF.md
# Mode-Dependent Multiplexed I/O Port

This block controls eight bidirectional pins from a small internal register bus. Three byte-wide registers sit behind fixed bus addresses: a write-only direction register, a readable data register and a readable pull-up register. For every pin, the block decides each cycle which source reaches the pad. The source is one of a general output bit, an external address bit, a PWM-style peripheral bit or nothing. When nothing drives the pin it is an input with its driver off.

The choice depends on several inputs. The operating mode selects either address-only operation or direction-controlled operation. An I/O-select bit hands the upper half of the pins to general output. A peripheral override on the top pin wins over every other source. Two standby inputs complete the set: hardware standby turns all drivers off and clears the direction bits, and software standby freezes the pins as they are. Pad outputs are registered, so a change in the registers or the inputs appears on the pins one clock later.

Top module: `pio_port_mux`

## Requirements
- R1: After a synchronous reset all three registers hold 8'h00, and pin_out, pin_oe and pull_en are all 8'h00.
- R2: The data register is at 16'hFFB3 and the pull-up register at 16'hFFAD, and both read back what was written. A read of any other address returns 8'h00. bus_rdata updates on the clock edge that samples bus_rd and holds its value until the next read.
- R3: The direction register is at 16'hFFB1 and cannot be read back: a read of that address returns 8'h00 whatever was written to it.
- R4: When mode is 2'd1, every pin drives its address bit with pin_oe high, whatever the direction bits are.
- R5: In any other mode, a pin whose direction bit is 0 is an input (pin_oe 0, pin_out 0). A pin whose direction bit is 1 drives its PWM bit when its pwm_sel bit is 1, and its address bit otherwise.
- R6: In a mode other than 2'd1 with io_sel high, pins 7 to 4 that have their direction bit set drive the matching data register bits in place of address or PWM.
- R7: While periph7_en is high, pin 7 drives periph7_out with pin_oe[7] high, in every mode and for either value of its direction bit.
- R8: While hw_stby is high, pin_oe, pin_out and pull_en are 0 one clock later. The direction register is cleared and ignores writes. The data and pull-up registers keep their contents.
- R9: While sw_stby is high and hw_stby is low, pin_out, pin_oe and pull_en keep the values they had when software standby was entered. The direction register keeps its contents for use after the exit.
- R10: pull_en[i] is 1 only when pin i is not driven and bit i of the pull-up register is 1.
- R11: A read of the data register returns, for each bit, the data register bit when that pin is driven and the synchronized pin_in level when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| mode | input | 2 | Operating mode; 2'd1 selects address-only operation |
| io_sel | input | 1 | Upper pins become general outputs |
| bus_addr | input | 16 | Register bus address (lower 16 bits) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| addr_bits | input | 8 | External address bits, one per pin |
| pwm_bits | input | 8 | Peripheral PWM bits, one per pin |
| pwm_sel | input | 8 | Per-pin choice of PWM over address |
| periph7_en | input | 1 | Peripheral override enable on pin 7 |
| periph7_out | input | 1 | Peripheral override level on pin 7 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pad pull-up enables |

## Verification
The hardest case to reach is the exit from standby with stale state. The direction register must survive software standby and then steer the pins again in a different mode. Hardware standby must instead leave it cleared even when a write is attempted in the middle of it. The stimulus first builds a mixed configuration with some pins driven, PWM on some pins and general output on the upper half. It then passes through software standby in address-only mode while the address bits change, which shows that the pins stayed frozen. After returning to direction-controlled mode it checks that the old direction bits still apply. Last, it writes the direction register during hardware standby and shows after the exit that every pin is an input and the pull-ups are back.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIN_W   = 8;
  localparam int unsigned BUS_AW  = 16;
  localparam logic [1:0]  MODE_ADDR_ONLY = 2'd1;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_GPO,
    SRC_ADDR,
    SRC_PWM,
    SRC_PERIPH
  } pin_src_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int unsigned     WIDTH    = 8,
  parameter int unsigned     AW       = 16,
  parameter logic [AW-1:0]   DIR_ADDR = 16'hFFB1,
  parameter logic [AW-1:0]   DAT_ADDR = 16'hFFB3,
  parameter logic [AW-1:0]   PU_ADDR  = 16'hFFAD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] driven,
  input  logic [WIDTH-1:0] pad_sync,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] pu_q,
  output logic [WIDTH-1:0] rdata_q
);
  logic hit_dir, hit_dat, hit_pu;
  logic [WIDTH-1:0] rd_mux;

  assign hit_dir = (bus_addr == DIR_ADDR);
  assign hit_dat = (bus_addr == DAT_ADDR);
  assign hit_pu  = (bus_addr == PU_ADDR);

  // direction bits: cleared by reset and hardware standby, never readable
  always_ff @(posedge clk) begin
    if (rst || hw_stby)      dir_q <= '0;
    else if (bus_wr && hit_dir) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                    dat_q <= '0;
    else if (bus_wr && hit_dat) dat_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                   pu_q <= '0;
    else if (bus_wr && hit_pu) pu_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_dat)     rd_mux = (dat_q & driven) | (pad_sync & ~driven);
    else if (hit_pu) rd_mux = pu_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
  import pio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hw_stby,
  input  logic sw_stby,
  input  logic addr_only,
  input  logic dir_bit,
  input  logic dat_bit,
  input  logic pu_bit,
  input  logic gpo_grant,
  input  logic pwm_pick,
  input  logic addr_bit,
  input  logic pwm_bit,
  input  logic ovr_en,
  input  logic ovr_val,
  output logic out_q,
  output logic oe_q,
  output logic pull_q
);
  pin_src_e src;
  logic     drive_n;
  logic     val_n;

  always_comb begin
    if (ovr_en)         src = SRC_PERIPH;
    else if (addr_only) src = SRC_ADDR;
    else if (!dir_bit)  src = SRC_NONE;
    else if (gpo_grant) src = SRC_GPO;
    else if (pwm_pick)  src = SRC_PWM;
    else                src = SRC_ADDR;
  end

  always_comb begin
    drive_n = 1'b1;
    unique case (src)
      SRC_PERIPH: val_n = ovr_val;
      SRC_ADDR:   val_n = addr_bit;
      SRC_PWM:    val_n = pwm_bit;
      SRC_GPO:    val_n = dat_bit;
      default: begin
        val_n   = 1'b0;
        drive_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hw_stby) begin
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      pull_q <= 1'b0;
    end else if (!sw_stby) begin
      out_q  <= val_n;
      oe_q   <= drive_n;
      pull_q <= pu_bit & ~drive_n;
    end
  end
endmodule

// File: rtl/pio_port_mux.sv
module pio_port_mux
  import pio_pkg::*;
#(
  parameter int unsigned       WIDTH       = PIN_W,
  parameter int unsigned       AW          = BUS_AW,
  parameter int unsigned       GPO_LOW_PIN = 4,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [AW-1:0]     DIR_ADDR    = 16'hFFB1,
  parameter logic [AW-1:0]     DAT_ADDR    = 16'hFFB3,
  parameter logic [AW-1:0]     PU_ADDR     = 16'hFFAD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic [1:0]       mode,
  input  logic             io_sel,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] addr_bits,
  input  logic [WIDTH-1:0] pwm_bits,
  input  logic [WIDTH-1:0] pwm_sel,
  input  logic             periph7_en,
  input  logic             periph7_out,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pull_en
);
  localparam int unsigned OVR_PIN = WIDTH - 1;

  logic [WIDTH-1:0] dir_q, dat_q, pu_q, pad_sync;
  logic             addr_only;

  assign addr_only = (mode == MODE_ADDR_ONLY);

  pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pad_sync)
  );

  pio_regs #(
    .WIDTH(WIDTH), .AW(AW),
    .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PU_ADDR(PU_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hw_stby   (hw_stby),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .driven    (pin_oe),
    .pad_sync  (pad_sync),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .pu_q      (pu_q),
    .rdata_q   (bus_rdata)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic gpo_ok, ovr_on;
      if (i >= GPO_LOW_PIN) begin : g_gpo
        assign gpo_ok = io_sel;
      end else begin : g_nogpo
        assign gpo_ok = 1'b0;
      end
      if (i == OVR_PIN) begin : g_ovr
        assign ovr_on = periph7_en;
      end else begin : g_noovr
        assign ovr_on = 1'b0;
      end

      pio_pin_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .addr_only (addr_only),
        .dir_bit   (dir_q[i]),
        .dat_bit   (dat_q[i]),
        .pu_bit    (pu_q[i]),
        .gpo_grant (gpo_ok),
        .pwm_pick  (pwm_sel[i]),
        .addr_bit  (addr_bits[i]),
        .pwm_bit   (pwm_bits[i]),
        .ovr_en    (ovr_on),
        .ovr_val   (periph7_out),
        .out_q     (pin_out[i]),
        .oe_q      (pin_oe[i]),
        .pull_q    (pull_en[i])
      );
    end
  endgenerate
endmodule

// File: rtl/pio_port_mux_chk.sv
module pio_port_mux_chk #(
  parameter int unsigned     WIDTH    = 8,
  parameter int unsigned     AW       = 16,
  parameter logic [AW-1:0]   DIR_ADDR = 16'hFFB1
) (
  input logic             clk,
  input logic             rst,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic [1:0]       mode,
  input logic             periph7_en,
  input logic             periph7_out,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pull_en
);
  // R8
  hw_stby_off_chk: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (pin_oe == '0 && pull_en == '0 && pin_out == '0));

  // R9
  sw_stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pull_en)));

  // R10
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_en & pin_oe) == '0);

  // R4
  addr_only_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && !hw_stby && !sw_stby) |=> (pin_oe == '1));

  // R3
  dir_unreadable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == DIR_ADDR) |=> (bus_rdata == '0));

  // R7
  periph_top_chk: assert property (@(posedge clk) disable iff (rst)
    (periph7_en && !hw_stby && !sw_stby) |=> (pin_oe[WIDTH-1] && pin_out[WIDTH-1] == $past(periph7_out)));
endmodule

bind pio_port_mux pio_port_mux_chk #(.WIDTH(WIDTH), .AW(AW), .DIR_ADDR(DIR_ADDR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_stby     (hw_stby),
  .sw_stby     (sw_stby),
  .mode        (mode),
  .periph7_en  (periph7_en),
  .periph7_out (periph7_out),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .pull_en     (pull_en)
);

// File: tb/tb_pio_port_mux.sv
module tb_pio_port_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_stby = 0, sw_stby = 0, io_sel = 0;
  logic [1:0]  mode = 2'd2;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [7:0]  addr_bits = 8'h96, pwm_bits = '0, pwm_sel = '0, pin_in = 8'h5A;
  logic        periph7_en = 0, periph7_out = 0;
  logic [7:0]  pin_out, pin_oe, pull_en;

  always #2 clk = ~clk;

  pio_port_mux dut (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
    .io_sel(io_sel), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_bits(addr_bits),
    .pwm_bits(pwm_bits), .pwm_sel(pwm_sel), .periph7_en(periph7_en),
    .periph7_out(periph7_out), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en)
  );

  typedef struct {
    bit         is_read;
    logic [7:0] e_out, e_oe, e_pu, e_rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: compares outputs against the next expected item
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.is_read) begin
        if (bus_rdata !== it.e_rd) begin
          errors++;
          $display("FAIL %s rdata=%h expected=%h", it.tag, bus_rdata, it.e_rd);
        end
      end else if (pin_out !== it.e_out || pin_oe !== it.e_oe || pull_en !== it.e_pu) begin
        errors++;
        $display("FAIL %s out/oe/pull=%h/%h/%h expected=%h/%h/%h",
                 it.tag, pin_out, pin_oe, pull_en, it.e_out, it.e_oe, it.e_pu);
      end
    end
  end

  task automatic push(input exp_t it);
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic expect_pins(input logic [7:0] o, input logic [7:0] oe,
                             input logic [7:0] pu, input string tag);
    exp_t it;
    settle();
    it.is_read = 0; it.e_out = o; it.e_oe = oe; it.e_pu = pu; it.e_rd = '0; it.tag = tag;
    push(it);
  endtask

  task automatic expect_read(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t it;
    settle();
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    it.is_read = 1; it.e_out = '0; it.e_oe = '0; it.e_pu = '0; it.e_rd = d; it.tag = tag;
    push(it);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    expect_pins(8'h00, 8'h00, 8'h00, "R1 reset outputs");
    expect_read(16'hFFB3, 8'h5A, "R1 R11 reset data reads pads");

    wr(16'hFFB3, 8'hA5);
    wr(16'hFFAD, 8'h3C);
    expect_read(16'hFFAD, 8'h3C, "R2 pull-up readback");
    expect_pins(8'h00, 8'h00, 8'h3C, "R10 all inputs pull-ups");
    expect_read(16'hFFB3, 8'h5A, "R11 inputs read synced pads");

    mode = 2'd1;
    expect_pins(8'h96, 8'hFF, 8'h00, "R4 address-only mode");
    expect_read(16'hFFB3, 8'hA5, "R11 R2 driven pins read data reg");

    mode = 2'd2;
    wr(16'hFFB1, 8'h0F);
    expect_pins(8'h06, 8'h0F, 8'h30, "R5 R10 low nibble address");
    pwm_sel = 8'h05; pwm_bits = 8'hFF;
    expect_pins(8'h07, 8'h0F, 8'h30, "R5 pwm select");
    wr(16'hFFB1, 8'hFF);
    io_sel = 1;
    expect_pins(8'hA7, 8'hFF, 8'h00, "R6 upper pins general output");
    wr(16'hFFB1, 8'h7F);
    periph7_en = 1; periph7_out = 0;
    expect_pins(8'h27, 8'hFF, 8'h00, "R7 override on undriven pin 7");
    periph7_en = 0;
    expect_pins(8'h27, 8'h7F, 8'h00, "R7 override released");
    expect_read(16'hFFB1, 8'h00, "R3 direction unreadable");
    expect_read(16'hFFAD, 8'h3C, "R2 pull-up readback again");
    expect_read(16'hFFB0, 8'h00, "R2 unmapped reads zero");
    pin_in = 8'hDA;
    expect_read(16'hFFB3, 8'hA5, "R11 mixed read");

    mode = 2'd1;
    expect_pins(8'h96, 8'hFF, 8'h00, "R4 before software standby");
    sw_stby = 1;
    settle();
    addr_bits = 8'h3C;
    expect_pins(8'h96, 8'hFF, 8'h00, "R9 frozen in software standby");
    sw_stby = 0;
    expect_pins(8'h3C, 8'hFF, 8'h00, "R9 resume after standby");
    mode = 2'd2;
    expect_pins(8'h2D, 8'h7F, 8'h00, "R9 direction retained");

    hw_stby = 1;
    expect_pins(8'h00, 8'h00, 8'h00, "R8 hardware standby off");
    wr(16'hFFB1, 8'hFF);
    hw_stby = 0;
    expect_pins(8'h00, 8'h00, 8'h3C, "R8 direction cleared after exit");
    expect_read(16'hFFAD, 8'h3C, "R8 pull-up kept");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule